// File: doc/BRIEF.md
# Guest Bus-Lock Budget Limiter

This block decides, request by request, whether a guest is allowed to perform an atomic operation that locks the shared bus. A hypervisor-side register window supplies two settings: a throttling enable and a 16-bit allowance of bus locks. Each guest entry copies the allowance into a private counter. When throttling is on, a lock request is granted only while the counter is above zero, and each grant uses up one unit. A request that arrives with the counter at zero is not granted. Instead the block raises a guest-exit pulse carrying a fixed exit code.

Lock requests arrive on a valid/ready handshake. A request is taken when `lock_req_valid` and `lock_req_ready` are both high at a rising clock edge. At most one request is taken per cycle. The requester must hold `lock_req_valid` high while `lock_req_ready` is low. Ready is dropped in two cases: in the cycle of a guest entry, and in every cycle after an exit until the next guest entry. The outcome of a taken request appears one cycle later, as a one-cycle pulse on either `lock_grant` or `guest_exit`. The remaining allowance is always visible on `budget_left`, and `cap_word` advertises that the function is present.

Top module: `blt_limiter`

## Requirements
- R1: During and right after reset, `budget_left` is 0, `lock_grant` and `guest_exit` are low, `exit_code` is 0, and `lock_req_ready` is high. Both stored settings are cleared, so throttling is off and the allowance is 0.
- R2: The register window behaves as follows:
  - A write (`cfg_we` high) to byte address 0x014 stores bit 5 of `cfg_wdata` as the throttling enable.
  - A write to byte address 0x120 stores bits 15:0 of `cfg_wdata` as the allowance.
  - A write to any other address changes nothing.
- R3: A cycle with `guest_entry` high loads the stored allowance into the counter, and the new value is visible on `budget_left` the next cycle. If a register write happens in that same cycle, the entry loads the value that was stored before the write.
- R4: With throttling on and the counter above zero, a taken request gives a `lock_grant` pulse in the next cycle, and the counter drops by one.
- R5: With throttling on and the counter at zero, a taken request gives a `guest_exit` pulse in the next cycle instead of a grant. `exit_code` reads 0x0A5 during that pulse, and the counter keeps its value.
- R6: With throttling off, every taken request is granted, and the counter is neither tested nor changed.
- R7: Each taken request produces exactly one one-cycle pulse, on `lock_grant` or on `guest_exit`. The two are never high together.
- R8: After an exit, `lock_req_ready` stays low, and `lock_req_valid` is ignored, until the next guest entry.
- R9: In a cycle with `guest_entry` high, `lock_req_ready` is low and no request is taken.
- R10: `cap_word` always reads 0x2000_0000, which is bit 29 set and every other bit clear.
- R11: `exit_code` is 0 in every cycle without a `guest_exit` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register window write strobe |
| cfg_addr | input | 12 | Byte address of the register write |
| cfg_wdata | input | 32 | Register write data |
| guest_entry | input | 1 | Guest entry event; loads the allowance |
| lock_req_valid | input | 1 | A bus-lock request is pending |
| lock_req_ready | output | 1 | The block can take a request this cycle |
| lock_grant | output | 1 | One-cycle pulse: the lock may proceed |
| guest_exit | output | 1 | One-cycle pulse: the lock is refused, exit requested |
| exit_code | output | 12 | Exit reason; 0x0A5 during `guest_exit`, otherwise 0 |
| budget_left | output | 16 | Current value of the internal counter |
| cap_word | output | 32 | Capability word with the support bit set |

## Verification
A guest entry and a pending lock request can arrive in the same cycle. A register write can also arrive in the same cycle as a guest entry. The bench provokes the first collision by raising `lock_req_valid` together with `guest_entry`, and expects ready to be low and no request to be taken. It provokes the second by writing a new allowance in the entry cycle, and expects the old allowance to be loaded. A behavioural model runs alongside the design. Random traffic mixes requests, entries, enable flips and allowance writes, so the model is compared against the design in the collision cycles too.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned CODE_W    = 12;
  localparam int unsigned CAP_BIT   = 29;
  localparam logic [CODE_W-1:0] LOCK_EXIT_CODE = 12'h0A5;
  localparam logic [ADDR_W-1:0] CTRL_OFS   = 12'h014;
  localparam logic [ADDR_W-1:0] BUDGET_OFS = 12'h120;
  localparam int unsigned EN_BIT    = 5;

  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'b00,
    VERDICT_GRANT = 2'b01,
    VERDICT_EXIT  = 2'b10
  } verdict_e;
endpackage

// File: rtl/blt_cfg_regs.sv
module blt_cfg_regs #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned EN_BIT = 5,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 12'h014,
  parameter logic [ADDR_W-1:0] BUDGET_OFS = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              throttle_en,
  output logic [CNT_W-1:0]  allowance
);
  logic hit_ctrl;
  logic hit_budget;

  assign hit_ctrl   = we && (addr == CTRL_OFS);
  assign hit_budget = we && (addr == BUDGET_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      throttle_en <= 1'b0;
      allowance   <= '0;
    end else begin
      if (hit_ctrl)   throttle_en <= wdata[EN_BIT];
      if (hit_budget) allowance   <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/blt_budget_ctr.sv
module blt_budget_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - 1'b1;
  end

  assign empty = (count == '0);
endmodule

// File: rtl/blt_gate.sv
module blt_gate
  import blt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     entry,
  input  logic     req_valid,
  input  logic     throttle_en,
  input  logic     empty,
  output logic     req_ready,
  output logic     dec,
  output verdict_e verdict
);
  logic     blocked_q;
  logic     take;
  verdict_e next_verdict;

  assign req_ready = !blocked_q && !entry;
  assign take      = req_valid && req_ready;

  always_comb begin
    next_verdict = VERDICT_NONE;
    dec          = 1'b0;
    if (take) begin
      if (!throttle_en) begin
        next_verdict = VERDICT_GRANT;
      end else if (!empty) begin
        next_verdict = VERDICT_GRANT;
        dec          = 1'b1;
      end else begin
        next_verdict = VERDICT_EXIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict   <= VERDICT_NONE;
      blocked_q <= 1'b0;
    end else begin
      verdict <= next_verdict;
      if (entry)                              blocked_q <= 1'b0;
      else if (next_verdict == VERDICT_EXIT)  blocked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/blt_limiter.sv
module blt_limiter
  import blt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              guest_entry,
  input  logic              lock_req_valid,
  output logic              lock_req_ready,
  output logic              lock_grant,
  output logic              guest_exit,
  output logic [CODE_W-1:0] exit_code,
  output logic [CNT_W-1:0]  budget_left,
  output logic [DATA_W-1:0] cap_word
);
  logic             throttle_en;
  logic [CNT_W-1:0] allowance;
  logic             cnt_empty;
  logic             cnt_dec;
  verdict_e         verdict;

  blt_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT),
    .CTRL_OFS(CTRL_OFS), .BUDGET_OFS(BUDGET_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .throttle_en(throttle_en), .allowance(allowance)
  );

  blt_budget_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(guest_entry), .load_val(allowance),
    .dec(cnt_dec), .count(budget_left), .empty(cnt_empty)
  );

  blt_gate u_gate (
    .clk(clk), .rst_n(rst_n), .entry(guest_entry), .req_valid(lock_req_valid),
    .throttle_en(throttle_en), .empty(cnt_empty), .req_ready(lock_req_ready),
    .dec(cnt_dec), .verdict(verdict)
  );

  assign lock_grant = (verdict == VERDICT_GRANT);
  assign guest_exit = (verdict == VERDICT_EXIT);
  assign exit_code  = guest_exit ? LOCK_EXIT_CODE : '0;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_cap
      if (b == CAP_BIT) begin : g_one
        assign cap_word[b] = 1'b1;
      end else begin : g_zero
        assign cap_word[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/blt_limiter_chk.sv
module blt_limiter_chk
  import blt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              guest_entry,
  input logic              lock_req_valid,
  input logic              lock_req_ready,
  input logic              lock_grant,
  input logic              guest_exit,
  input logic [CODE_W-1:0] exit_code,
  input logic [CNT_W-1:0]  budget_left,
  input logic              throttle_en,
  input logic [CNT_W-1:0]  allowance
);
  logic taken;
  assign taken = lock_req_valid && lock_req_ready;

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_grant && guest_exit));

  p_grant_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    taken && throttle_en && budget_left != '0
    |=> lock_grant && budget_left == $past(budget_left) - 1'b1);

  p_exit_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    taken && throttle_en && budget_left == '0
    |=> guest_exit && exit_code == LOCK_EXIT_CODE && $stable(budget_left));

  p_free_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !throttle_en |=> lock_grant && $stable(budget_left));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    guest_entry |=> budget_left == $past(allowance));

  p_entry_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    guest_entry |-> !lock_req_ready);

  p_hold_after_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    guest_exit |-> !lock_req_ready);

  p_code_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !guest_exit |-> exit_code == '0);

  p_no_req_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> !lock_grant && !guest_exit);
endmodule

bind blt_limiter blt_limiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .guest_entry(guest_entry),
  .lock_req_valid(lock_req_valid), .lock_req_ready(lock_req_ready),
  .lock_grant(lock_grant), .guest_exit(guest_exit), .exit_code(exit_code),
  .budget_left(budget_left), .throttle_en(throttle_en), .allowance(allowance)
);

// File: tb/blt_limiter_tb_top.sv
`timescale 1ns/1ps
module blt_limiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        guest_entry = 1'b0;
  logic        lock_req_valid = 1'b0;
  logic        lock_req_ready;
  logic        lock_grant;
  logic        guest_exit;
  logic [11:0] exit_code;
  logic [15:0] budget_left;
  logic [31:0] cap_word;

  always #2.5 clk = ~clk;

  blt_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .guest_entry(guest_entry),
    .lock_req_valid(lock_req_valid), .lock_req_ready(lock_req_ready),
    .lock_grant(lock_grant), .guest_exit(guest_exit), .exit_code(exit_code),
    .budget_left(budget_left), .cap_word(cap_word)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_grant_seen = 0;
  int n_exit_seen = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  bit m_en;
  int m_allow;
  int m_count;
  bit m_blocked;
  bit m_grant;
  bit m_exit;

  always @(posedge clk) begin
    bit take;
    take = lock_req_valid && !m_blocked && !guest_entry;
    if (!rst_n) begin
      m_en <= 0; m_allow <= 0; m_count <= 0; m_blocked <= 0;
      m_grant <= 0; m_exit <= 0;
    end else begin
      if (cfg_we && cfg_addr == 12'h014) m_en <= cfg_wdata[5];
      if (cfg_we && cfg_addr == 12'h120) m_allow <= int'(cfg_wdata[15:0]);
      m_grant <= 0;
      m_exit  <= 0;
      if (guest_entry) begin
        m_count   <= m_allow;
        m_blocked <= 0;
      end else if (take) begin
        if (!m_en) m_grant <= 1;
        else if (m_count > 0) begin
          m_grant <= 1;
          m_count <= m_count - 1;
        end else begin
          m_exit    <= 1;
          m_blocked <= 1;
        end
      end
    end
  end

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (compare_on && !done) begin
      check("R4 budget_left", budget_left, m_count);
      check("R4 lock_grant", lock_grant, m_grant);
      check("R5 guest_exit", guest_exit, m_exit);
      check("R11 exit_code", exit_code, m_exit ? 12'h0A5 : 12'h000);
      check("R8 lock_req_ready", lock_req_ready, !m_blocked && !guest_entry);
      check("R10 cap_word", cap_word, 32'h2000_0000);
      if (lock_grant) n_grant_seen++;
      if (guest_exit) n_exit_seen++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic enter();
    guest_entry = 1;
    cyc(1);
    guest_entry = 0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    int lfsr;
    cyc(3);
    compare_on = 1'b1;
    cyc(1);
    // R1 reset values
    check("R1 budget_left", budget_left, 0);
    check("R1 ready", lock_req_ready, 1);
    check("R1 grant/exit", {lock_grant, guest_exit}, 0);
    rst_n = 1;
    cyc(1);

    // R2 register window, R3 load
    reg_wr(12'h120, 32'hABCD_0003);
    reg_wr(12'h014, 32'h0000_0020);
    reg_wr(12'h118, 32'h0000_FFFF);
    reg_wr(12'h124, 32'h0000_0000);
    enter();
    check("R2/R3 loaded allowance", budget_left, 3);

    // R4, R5, R7, R8: three grants then exit, then stalled
    n_grant_seen = 0; n_exit_seen = 0;
    lock_req_valid = 1;
    cyc(6);
    check("R7 grant count", n_grant_seen, 3);
    check("R7 exit count", n_exit_seen, 1);
    check("R8 ready after exit", lock_req_ready, 0);
    check("R5 count kept", budget_left, 0);

    // R9 entry with request pending
    guest_entry = 1;
    #1;
    check("R9 ready in entry cycle", lock_req_ready, 0);
    cyc(1);
    guest_entry = 0;
    check("R9 no take in entry cycle", budget_left, 3);
    cyc(2);
    lock_req_valid = 0;
    check("R4 two grants", budget_left, 1);

    // R6 throttling off
    reg_wr(12'h014, 32'h0000_0000);
    n_grant_seen = 0; n_exit_seen = 0;
    lock_req_valid = 1;
    cyc(4);
    lock_req_valid = 0;
    cyc(1);
    check("R6 count untouched", budget_left, 1);
    check("R6 all granted", n_grant_seen, 4);
    check("R6 no exit", n_exit_seen, 0);

    // R5 zero allowance: immediate exit
    reg_wr(12'h120, 32'h0);
    reg_wr(12'h014, 32'h20);
    enter();
    n_exit_seen = 0;
    lock_req_valid = 1;
    cyc(1);
    lock_req_valid = 0;
    cyc(1);
    check("R5 immediate exit", n_exit_seen, 1);

    // R3 write in entry cycle loads old value
    reg_wr(12'h120, 32'h5);
    cfg_we = 1; cfg_addr = 12'h120; cfg_wdata = 32'h7; guest_entry = 1;
    cyc(1);
    cfg_we = 0; guest_entry = 0;
    check("R3 old allowance on collision", budget_left, 5);
    enter();
    check("R3 new allowance", budget_left, 7);

    // large allowance
    reg_wr(12'h120, 32'hFFFF);
    enter();
    lock_req_valid = 1;
    cyc(3);
    lock_req_valid = 0;
    check("R4 from max", budget_left, 16'hFFFC);

    // mixed traffic
    lfsr = 32'h1ACE;
    for (int i = 0; i < 600; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13)) & 1);
      lfsr = lfsr & 16'hFFFF;
      lock_req_valid = lfsr[0] | lfsr[3];
      guest_entry    = (lfsr[7:4] == 4'h3);
      cfg_we         = (lfsr[11:9] == 3'h5);
      cfg_addr       = lfsr[2] ? 12'h120 : 12'h014;
      cfg_wdata      = {16'h0, 12'h0, lfsr[14:12], 1'b0} | (lfsr[8] ? 32'h20 : 32'h0);
      cyc(1);
    end
    lock_req_valid = 0; guest_entry = 0; cfg_we = 0;
    cyc(2);
    finish_up();
  end
endmodule